// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits between on-chip logic and a serial NOR flash on a four-wire SPI link. A client hands it one request at a time: fetch the device identifier, set the write-enable latch, read the status byte, program a run of bytes, or read a run of bytes. The block expands each request into one or more chip-select framed transactions. Each transaction carries an instruction byte and, where needed, address, dummy and data bytes. SCK, MOSI and chip select are driven in SPI mode 0, and MISO is sampled on the rising clock edge.

A program request may span several 256-byte pages. It is cut into page-bounded pieces. Each piece is preceded by its own write-enable transaction and followed by status polling until the flash reports it is no longer busy. Write bytes are pulled from the client one at a time through a ready strobe. Read bytes, the status byte and the identifier are returned through a valid strobe. A single-cycle done pulse closes every accepted request. The SCK rate is set by a divider parameter counted in system clocks.

Top module: `spi_flash_seq`

## Requirements
- R1: Every transaction starts with cs_no falling and ends with it rising after a whole number of bytes. The first byte is the instruction, and every byte is sent and received MSB first.
- R2: SPI mode 0 is used. sck_o is low whenever cs_no is high, and mosi_o does not change while sck_o is high.
- R3: sck_o stays high for HALF_DIV system clocks per pulse. cs_no stays high for at least 2*HALF_DIV system clocks between transactions and before done_o is raised.
- R4: req_op_i encodes 0 = identify, 1 = write enable, 2 = status, 3 = program, 4 = read. Codes 5 to 7 are accepted and ignored: no bus activity and no done_o.
- R5: Identify sends 0xAB and three 0x00 dummy bytes, then one more byte. The byte received in that fifth slot is returned on rd_valid_o. id_err_o is set when it differs from EXP_ID (0x15) and cleared when it matches.
- R6: Write enable issues a single one-byte transaction with instruction 0x06.
- R7: Status issues 0x05 followed by one byte, and returns the received byte on rd_valid_o.
- R8: Read issues 0x03, then the 24-bit address most significant byte first, then req_len_i further bytes. Each received data byte is returned in order on rd_valid_o.
- R9: Program writes each piece as 0x02, then the 24-bit address, then the data bytes. Each data byte is taken from wr_data_i in the cycle wr_ready_o is high. Every piece is preceded by a 0x06 transaction.
- R10: No program piece crosses a 256-byte page boundary. A request that does cross one is split at the boundary.
- R11: After each program transaction, 0x05 transactions repeat while status bit 0 (busy) reads 1. The next piece, or done_o, follows only after busy reads 0.
- R12: done_o is a one-cycle pulse per accepted valid request. A program or read request with length 0 finishes with done_o and no bus activity.
- R13: req_ready_o is high only while the block is idle, and chip select is then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when req_ready_o is high |
| req_op_i | input | 3 | Request code |
| req_addr_i | input | 24 | Flash start address |
| req_len_i | input | LEN_W | Byte count for program or read |
| req_ready_o | output | 1 | Idle, can take a request |
| wr_data_i | input | 8 | Program data byte |
| wr_ready_o | output | 1 | wr_data_i is consumed this cycle |
| rd_data_o | output | 8 | Returned byte |
| rd_valid_o | output | 1 | rd_data_o is valid |
| done_o | output | 1 | Request finished, one-cycle pulse |
| id_err_o | output | 1 | Last identifier did not match EXP_ID |
| cs_no | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The properties watch the framing and mode-0 rules on every cycle. They check that SCK stays low with chip select high, that MOSI holds while SCK is high, that clock pulses occur only inside a frame, that write data is requested only inside a frame, that done is a single-cycle pulse, and that the block reports ready only with chip select high. Instruction ordering, address bytes, page splitting, the number of busy polls and the returned data cannot be seen by those properties. The bench shows them by driving a behavioural flash model and comparing its transaction log and memory contents with sequences worked out from the request. The divider-derived pulse widths and chip-select gaps are also measured by the bench on every clock.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
  localparam logic [2:0] OP_ID   = 3'd0;
  localparam logic [2:0] OP_WREN = 3'd1;
  localparam logic [2:0] OP_STAT = 3'd2;
  localparam logic [2:0] OP_PROG = 3'd3;
  localparam logic [2:0] OP_READ = 3'd4;

  localparam logic [7:0] INS_ID   = 8'hAB;
  localparam logic [7:0] INS_WREN = 8'h06;
  localparam logic [7:0] INS_RDSR = 8'h05;
  localparam logic [7:0] INS_PP   = 8'h02;
  localparam logic [7:0] INS_RD   = 8'h03;

  typedef enum logic [2:0] {
    TX_ID, TX_WREN, TX_STAT, TX_PROG, TX_READ, TX_POLL
  } txn_e;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_GAP} seq_st_e;
endpackage

// File: rtl/spi_flash_clkgen.sv
module spi_flash_clkgen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clear_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_flash_shift.sv
module spi_flash_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  logic       busy_q, sck_q, done_q;
  logic [2:0] bit_q;
  logic [7:0] sr_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= '0;
      sr_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sr_q   <= tx_i;
        bit_q  <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (!sck_q) begin
          // rising edge: sample
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};
        end else begin
          // falling edge: advance
          sck_q <= 1'b0;
          sr_q  <= {sr_q[6:0], 1'b0};
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = sr_q[7];
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl import spi_flash_pkg::*; #(
  parameter int             LEN_W      = 16,
  parameter int             PAGE_BYTES = 256,
  parameter logic [7:0]     EXP_ID     = 8'h15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_op_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_ready_o,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             id_err_o,
  output logic             cs_no,
  input  logic             tick_i,
  output logic             clk_clear_o,
  output logic             sh_start_o,
  output logic [7:0]       sh_tx_o,
  input  logic             sh_done_i,
  input  logic [7:0]       sh_rx_i
);
  localparam int TW = LEN_W + 1;
  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [TW-1:0] HDR = TW'(4);

  seq_st_e          st_q;
  txn_e             txn_q;
  logic             cs_q, done_q, rd_valid_q, id_err_q, gap_q, busy_seen_q, prog_q;
  logic [7:0]       rd_data_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] rem_q;
  logic [TW-1:0]    idx_q, tot_q, chunk_q;
  logic [TW-1:0]    room_c, rem_c, chunk_c;
  logic             last_c, data_ph_c;

  assign room_c    = TW'(PAGE_BYTES) - TW'(addr_q[PW-1:0]);
  assign rem_c     = {1'b0, rem_q};
  assign chunk_c   = (rem_c < room_c) ? rem_c : room_c;
  assign last_c    = (idx_q + TW'(1)) == tot_q;
  assign data_ph_c = idx_q >= HDR;

  always_comb begin
    sh_tx_o = 8'h00;
    unique case (txn_q)
      TX_ID:           if (idx_q == '0) sh_tx_o = INS_ID;
      TX_WREN:         sh_tx_o = INS_WREN;
      TX_STAT, TX_POLL: if (idx_q == '0) sh_tx_o = INS_RDSR;
      TX_READ, TX_PROG: begin
        if (idx_q == TW'(0))      sh_tx_o = (txn_q == TX_PROG) ? INS_PP : INS_RD;
        else if (idx_q == TW'(1)) sh_tx_o = addr_q[23:16];
        else if (idx_q == TW'(2)) sh_tx_o = addr_q[15:8];
        else if (idx_q == TW'(3)) sh_tx_o = addr_q[7:0];
        else if (txn_q == TX_PROG) sh_tx_o = wr_data_i;
      end
      default: sh_tx_o = 8'h00;
    endcase
  end

  assign sh_start_o  = (st_q == S_LOAD);
  assign clk_clear_o = (st_q == S_LOAD) || (st_q == S_RUN && sh_done_i);
  assign wr_ready_o  = (st_q == S_LOAD) && (txn_q == TX_PROG) && data_ph_c;
  assign req_ready_o = (st_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      txn_q       <= TX_ID;
      cs_q        <= 1'b1;
      done_q      <= 1'b0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= '0;
      id_err_q    <= 1'b0;
      gap_q       <= 1'b0;
      busy_seen_q <= 1'b0;
      prog_q      <= 1'b0;
      addr_q      <= '0;
      rem_q       <= '0;
      idx_q       <= '0;
      tot_q       <= '0;
      chunk_q     <= '0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          addr_q <= req_addr_i;
          rem_q  <= req_len_i;
          prog_q <= (req_op_i == OP_PROG);
          idx_q  <= '0;
          unique case (req_op_i)
            OP_ID:   begin txn_q <= TX_ID;   tot_q <= TW'(5); cs_q <= 1'b0; st_q <= S_LOAD; end
            OP_WREN: begin txn_q <= TX_WREN; tot_q <= TW'(1); cs_q <= 1'b0; st_q <= S_LOAD; end
            OP_STAT: begin txn_q <= TX_STAT; tot_q <= TW'(2); cs_q <= 1'b0; st_q <= S_LOAD; end
            OP_PROG: begin
              if (req_len_i == '0) done_q <= 1'b1;
              else begin txn_q <= TX_WREN; tot_q <= TW'(1); cs_q <= 1'b0; st_q <= S_LOAD; end
            end
            OP_READ: begin
              if (req_len_i == '0) done_q <= 1'b1;
              else begin
                txn_q <= TX_READ;
                tot_q <= HDR + {1'b0, req_len_i};
                cs_q  <= 1'b0;
                st_q  <= S_LOAD;
              end
            end
            default: ;
          endcase
        end
        S_LOAD: st_q <= S_RUN;
        S_RUN: if (sh_done_i) begin
          rd_data_q <= sh_rx_i;
          if (txn_q == TX_ID && idx_q == TW'(4)) begin
            rd_valid_q <= 1'b1;
            id_err_q   <= (sh_rx_i != EXP_ID);
          end
          if (txn_q == TX_STAT && idx_q == TW'(1)) rd_valid_q <= 1'b1;
          if (txn_q == TX_READ && data_ph_c)       rd_valid_q <= 1'b1;
          if (txn_q == TX_POLL && idx_q == TW'(1)) busy_seen_q <= sh_rx_i[0];
          if (last_c) begin
            cs_q  <= 1'b1;
            gap_q <= 1'b0;
            st_q  <= S_GAP;
            if (txn_q == TX_PROG) begin
              addr_q <= addr_q + 24'(chunk_q);
              rem_q  <= rem_q - LEN_W'(chunk_q);
            end
          end else begin
            idx_q <= idx_q + TW'(1);
            st_q  <= S_LOAD;
          end
        end
        S_GAP: if (tick_i) begin
          if (!gap_q) gap_q <= 1'b1;
          else begin
            idx_q <= '0;
            unique case (txn_q)
              TX_WREN: begin
                if (prog_q) begin
                  txn_q   <= TX_PROG;
                  chunk_q <= chunk_c;
                  tot_q   <= HDR + chunk_c;
                  cs_q    <= 1'b0;
                  st_q    <= S_LOAD;
                end else begin
                  done_q <= 1'b1;
                  st_q   <= S_IDLE;
                end
              end
              TX_PROG: begin
                txn_q <= TX_POLL;
                tot_q <= TW'(2);
                cs_q  <= 1'b0;
                st_q  <= S_LOAD;
              end
              TX_POLL: begin
                if (busy_seen_q) begin
                  cs_q <= 1'b0;
                  st_q <= S_LOAD;
                end else if (rem_q == '0) begin
                  done_q <= 1'b1;
                  st_q   <= S_IDLE;
                end else begin
                  txn_q <= TX_WREN;
                  tot_q <= TW'(1);
                  cs_q  <= 1'b0;
                  st_q  <= S_LOAD;
                end
              end
              default: begin
                done_q <= 1'b1;
                st_q   <= S_IDLE;
              end
            endcase
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cs_no      = cs_q;
  assign done_o     = done_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign id_err_o   = id_err_q;
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int         HALF_DIV   = 50,
  parameter int         LEN_W      = 16,
  parameter int         PAGE_BYTES = 256,
  parameter logic [7:0] EXP_ID     = 8'h15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_op_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_ready_o,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             id_err_o,
  output logic             cs_no,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic       tick, clk_clear, sh_start, sh_done;
  logic [7:0] sh_tx, sh_rx;

  spi_flash_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clk_clear),
    .tick_o  (tick)
  );

  spi_flash_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .start_i (sh_start),
    .tx_i    (sh_tx),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i)
  );

  spi_flash_ctrl #(
    .LEN_W      (LEN_W),
    .PAGE_BYTES (PAGE_BYTES),
    .EXP_ID     (EXP_ID)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .req_ready_o (req_ready_o),
    .wr_data_i   (wr_data_i),
    .wr_ready_o  (wr_ready_o),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o),
    .done_o      (done_o),
    .id_err_o    (id_err_o),
    .cs_no       (cs_no),
    .tick_i      (tick),
    .clk_clear_o (clk_clear),
    .sh_start_o  (sh_start),
    .sh_tx_o     (sh_tx),
    .sh_done_i   (sh_done),
    .sh_rx_i     (sh_rx)
  );
endmodule

// File: rtl/spi_flash_seq_chk.sv
module spi_flash_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sck_o,
  input logic mosi_o,
  input logic done_o,
  input logic req_ready_o,
  input logic wr_ready_o
);
  a_r2_sck_low_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  a_r2_mosi_held_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  a_r1_pulse_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> !cs_no);

  a_r12_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r13_ready_only_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_no);

  a_r9_data_pull_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> (!cs_no && !sck_o));
endmodule

bind spi_flash_seq spi_flash_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_no       (cs_no),
  .sck_o       (sck_o),
  .mosi_o      (mosi_o),
  .done_o      (done_o),
  .req_ready_o (req_ready_o),
  .wr_ready_o  (wr_ready_o)
);

// File: tb/spi_flash_seq_test.sv
module spi_flash_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_ready, wr_ready, rd_valid, done, id_err, cs_n, sck, mosi;
  logic [7:0]  wr_data, rd_data;
  logic        miso = 1'b0;

  int n_cmp = 0, n_bad = 0;
  int wr_ptr = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wr_data = 8'(wr_ptr * 13 + 5);
  always @(posedge clk) if (wr_ready) wr_ptr <= wr_ptr + 1;

  spi_flash_seq #(.HALF_DIV(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_ready_o(req_ready),
    .wr_data_i(wr_data), .wr_ready_o(wr_ready), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .done_o(done), .id_err_o(id_err), .cs_no(cs_n),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- behavioural flash ----------------
  logic [7:0]  mem [int];
  logic [7:0]  dev_id = 8'h15;
  bit          wel = 0;
  int          busy_left = 0;
  int          bcnt = 0, bitc = 0, nz_dummy = 0;
  logic [7:0]  in_sr = '0, out_sr = '0, cur_ins = '0;
  logic [23:0] cur_adr = '0;
  int          log_ins[$], log_len[$], log_adr[$], log_algn[$];

  function automatic logic [7:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  task automatic got_byte(input logic [7:0] b);
    int i = bcnt;
    if (i == 0) cur_ins = b;
    else if (i <= 3 && (cur_ins == 8'h02 || cur_ins == 8'h03)) cur_adr = {cur_adr[15:0], b};
    else if (i <= 3 && cur_ins == 8'hAB && b != 8'h00) nz_dummy++;
    if (cur_ins == 8'h02 && i >= 4 && wel) mem[int'(cur_adr) + i - 4] = b;
    bcnt++;
    case (cur_ins)
      8'hAB:   out_sr = (bcnt == 4) ? dev_id : 8'h00;
      8'h05:   out_sr = {6'b0, wel, busy_left > 0};
      8'h03:   out_sr = (bcnt >= 4) ? mem_rd(int'(cur_adr) + bcnt - 4) : 8'h00;
      default: out_sr = 8'h00;
    endcase
  endtask

  always @(negedge cs_n) begin
    bcnt = 0; bitc = 0; out_sr = '0; miso = 1'b0; cur_adr = '0; cur_ins = '0;
  end
  always @(posedge sck) if (!cs_n) begin
    in_sr = {in_sr[6:0], mosi};
    bitc++;
    if (bitc % 8 == 0) got_byte(in_sr);
  end
  always @(negedge sck) if (!cs_n) begin
    miso = out_sr[7];
    out_sr = {out_sr[6:0], 1'b0};
  end
  always @(posedge cs_n) if (rst_n) begin
    log_ins.push_back(int'(cur_ins));
    log_len.push_back(bcnt);
    log_adr.push_back(int'(cur_adr));
    log_algn.push_back(bitc % 8 == 0);
    if (cur_ins == 8'h06) wel = 1;
    if (cur_ins == 8'h02 && wel) begin wel = 0; busy_left = 3; end
    if (cur_ins == 8'h05 && bcnt >= 2 && busy_left > 0) busy_left--;
  end

  // ---------------- per-clock reference checks ----------------
  logic [7:0] rd_q[$];
  bit prev_sck = 0, prev_mosi = 0, prev_cs = 1;
  int hi_cnt = 0, cs_hi = 1000;

  always @(negedge clk) if (rst_n) begin
    if (rd_valid) rd_q.push_back(rd_data);
    chk(!(cs_n && sck), "R2 sck idle low", sck, 0);
    if (sck && prev_sck) chk(mosi == prev_mosi, "R2 mosi hold", mosi, prev_mosi);
    if (sck) hi_cnt++;
    if (prev_sck && !sck) begin chk(hi_cnt == HALF, "R3 high width", hi_cnt, HALF); hi_cnt = 0; end
    if (cs_n) cs_hi++;
    if (prev_cs && !cs_n) begin chk(cs_hi >= 2*HALF, "R3 cs gap", cs_hi, 2*HALF); cs_hi = 0; end
    if (done) chk(cs_n && cs_hi >= 2*HALF, "R3 gap before done", cs_hi, 2*HALF);
    if (req_ready) chk(cs_n, "R13 ready with cs high", cs_n, 1);
    prev_sck = sck; prev_mosi = mosi; prev_cs = cs_n;
  end

  // ---------------- stimulus helpers ----------------
  int exp_ins[$], exp_len[$], exp_adr[$];

  task automatic expect_txn(input int ins, input int len, input int adr);
    exp_ins.push_back(ins); exp_len.push_back(len); exp_adr.push_back(adr);
  endtask

  task automatic chk_log(input string rq);
    chk(log_ins.size() == exp_ins.size(), {rq, " txn count"}, log_ins.size(), exp_ins.size());
    for (int i = 0; i < exp_ins.size() && i < log_ins.size(); i++) begin
      chk(log_ins[i] == exp_ins[i], {rq, " instruction"}, log_ins[i], exp_ins[i]);
      chk(log_len[i] == exp_len[i], {rq, " byte count"}, log_len[i], exp_len[i]);
      if (exp_adr[i] >= 0) chk(log_adr[i] == exp_adr[i], {rq, " address"}, log_adr[i], exp_adr[i]);
      chk(log_algn[i] == 1, "R1 byte aligned frame", log_algn[i], 1);
    end
    log_ins.delete(); log_len.delete(); log_adr.delete(); log_algn.delete();
    exp_ins.delete(); exp_len.delete(); exp_adr.delete();
  endtask

  task automatic do_req(input logic [2:0] op, input logic [23:0] a, input int n);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = 16'(n);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string rq);
    int n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    chk(done, {rq, " done seen"}, done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && done == 0, "R1 reset outputs", {cs_n, sck, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1, "R13 ready after reset", req_ready, 1);

    // R5 identify, matching
    rd_q.delete();
    do_req(3'd0, 24'h0, 0); wait_done("R5");
    expect_txn(8'hAB, 5, -1); chk_log("R5");
    chk(rd_q.size() == 1 && rd_q[0] == 8'h15, "R5 id byte", rd_q.size() > 0 ? rd_q[0] : -1, 8'h15);
    chk(id_err == 0, "R5 id match", id_err, 0);
    chk(nz_dummy == 0, "R5 dummy zero", nz_dummy, 0);

    // R5 identify, mismatch
    dev_id = 8'h33; rd_q.delete();
    do_req(3'd0, 24'h0, 0); wait_done("R5");
    expect_txn(8'hAB, 5, -1); chk_log("R5");
    chk(rd_q.size() == 1 && rd_q[0] == 8'h33, "R5 id byte", rd_q.size() > 0 ? rd_q[0] : -1, 8'h33);
    chk(id_err == 1, "R5 id mismatch", id_err, 1);
    dev_id = 8'h15;

    // R7 status, idle flash
    rd_q.delete();
    do_req(3'd2, 24'h0, 0); wait_done("R7");
    expect_txn(8'h05, 2, -1); chk_log("R7");
    chk(rd_q.size() == 1 && rd_q[0] == 8'h00, "R7 status", rd_q.size() > 0 ? rd_q[0] : -1, 0);

    // R6 write enable, seen through status (WEL is bit 1)
    do_req(3'd1, 24'h0, 0); wait_done("R6");
    expect_txn(8'h06, 1, -1); chk_log("R6");
    rd_q.delete();
    do_req(3'd2, 24'h0, 0); wait_done("R6");
    expect_txn(8'h05, 2, -1); chk_log("R6");
    chk(rd_q.size() == 1 && rd_q[0] == 8'h02, "R6 latch set", rd_q.size() > 0 ? rd_q[0] : -1, 2);

    // R4 undefined op ignored
    begin
      bit saw_done = 0;
      do_req(3'd5, 24'h0, 4);
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (done || !cs_n) saw_done = 1; end
      chk(!saw_done, "R4 no activity", saw_done, 0);
      chk(log_ins.size() == 0, "R4 no transaction", log_ins.size(), 0);
      chk(req_ready == 1, "R4 still ready", req_ready, 1);
    end

    // R12 zero-length program and read
    do_req(3'd3, 24'h000010, 0); wait_done("R12");
    do_req(3'd4, 24'h000010, 0); wait_done("R12");
    repeat (10) @(negedge clk);
    chk(log_ins.size() == 0, "R12 no bus for zero length", log_ins.size(), 0);

    // R9 R10 R11 program across a page boundary
    wr_ptr = 0;
    do_req(3'd3, 24'h0100F0, 40); wait_done("R11");
    expect_txn(8'h06, 1, -1);
    expect_txn(8'h02, 4 + 16, 24'h0100F0);
    for (int i = 0; i < 4; i++) expect_txn(8'h05, 2, -1);
    expect_txn(8'h06, 1, -1);
    expect_txn(8'h02, 4 + 24, 24'h010100);
    for (int i = 0; i < 4; i++) expect_txn(8'h05, 2, -1);
    chk_log("R10");
    chk(wr_ptr == 40, "R9 bytes pulled", wr_ptr, 40);
    for (int k = 0; k < 40; k++)
      chk(mem_rd(24'h0100F0 + k) == 8'(k * 13 + 5), "R9 stored byte",
          mem_rd(24'h0100F0 + k), 8'(k * 13 + 5));

    // R8 read back
    rd_q.delete();
    do_req(3'd4, 24'h0100F0, 40); wait_done("R8");
    expect_txn(8'h03, 44, 24'h0100F0); chk_log("R8");
    chk(rd_q.size() == 40, "R8 read count", rd_q.size(), 40);
    for (int k = 0; k < 40 && k < rd_q.size(); k++)
      chk(rd_q[k] == 8'(k * 13 + 5), "R8 read byte", rd_q[k], 8'(k * 13 + 5));

    // R8 read of erased area
    rd_q.delete();
    do_req(3'd4, 24'h002000, 3); wait_done("R8");
    expect_txn(8'h03, 7, 24'h002000); chk_log("R8");
    chk(rd_q.size() == 3 && rd_q[2] == 8'hFF, "R8 erased read", rd_q.size() > 2 ? rd_q[2] : -1, 8'hFF);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule